// File: doc/BRIEF.md
# ATM Receive Cell Delineator and Filter

This block takes a byte-aligned receive stream and finds the 53-byte cell boundaries by testing the header check byte. The check byte is a CRC-8 over the four header bytes. While the block is searching, it tests every byte offset. Once it is locked, it tests only the header position of each cell. A small state machine moves the block through search, provisional lock and confirmed lock.

When the block is locked, it can descramble with a self-synchronous x^43+1 descrambler, applied either to the payload alone or to the whole cell. It can repair a header that has a single-bit error. It keeps separate saturating tallies of repaired cells and of cells with an error it could not repair.

Each cell is classified from its header and then either discarded or passed to the system side. Only cells whose header was tested while the block held confirmed lock are passed. The system side receives each passed cell with or without its check byte, marked with start-of-cell and end-of-cell flags. Output lags the line by five bytes.

Top module: `atm_cell_delineator`

## Requirements
- R1: After reset, `sync_state` is 0 (search), `out_valid` is low and both tally outputs read 0. `out_valid` only rises on the edge after a clock with `in_valid` high.
- R2: The header check value is the CRC-8 with polynomial x^8+x^2+x+1 over the four header bytes, first byte first and MSB first, starting from zero. It is XORed with 0x55 when `cfg_coset_en` is 1. In search (`sync_state` 0), a match at any offset moves the block to provisional lock (`sync_state` 1).
- R3: In provisional lock, DELTA (6) consecutive matching headers move the block to confirmed lock (`sync_state` 2), and one mismatch returns it to search. Only cells whose header is tested in confirmed lock are forwarded.
- R4: In confirmed lock, ALPHA (7) consecutive headers with an error that is not repaired return the block to search. A good header or a repaired header restarts that run.
- R5: With `cfg_correct_en` set, in confirmed lock and in repair mode, a header with a single-bit error in its 40 bits is repaired. It is forwarded with the repaired header and check byte and adds one to the repaired tally.
- R6: After a repair or a detected error, the next cell is only checked, not repaired. Any error in that cell adds one to the unrepaired tally. An error-free cell restores repair mode.
- R7: A cell with an unrepaired error is discarded when `cfg_drop_errored` is 1. When it is 0, the cell is forwarded exactly as received.
- R8: Class drops apply in any combination. Idle means header 0x00000001. Unassigned means header bits [27:4] are zero and bit 0 is 0. Invalid means bits [27:4] are zero, bit 0 is 1, and the header is not idle. Match means `((hdr ^ cfg_hdr_value) & cfg_hdr_mask) == 0`. With all drop bits clear, nothing is dropped by class.
- R9: With `cfg_match_only` set, only matching cells are forwarded, and the class drop bits are ignored.
- R10: `out_sof` flags header byte 0 and `out_eof` flags payload byte 47. Both are only high with `out_valid`. The check byte (cell byte 4) is forwarded only when `cfg_hec_keep` is 1.
- R11: `cfg_dscr_mode` = 1 descrambles payload bytes with x^43+1. The descrambler runs bytewise and MSB first, and its history holds received payload bits only.
- R12: `cfg_dscr_mode` = 2 or 3 descrambles every byte, with a history of all received bits, before the header test. Delineation and forwarding still work in this mode.
- R13: With `cfg_coset_en` 0, headers carrying a check value without 0x55 are accepted.
- R14: The tallies saturate at 2^CNT_W-1. A one-cycle `cnt_latch` copies both tallies to the outputs and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Line byte present |
| in_data | input | 8 | Line byte |
| cfg_dscr_mode | input | 2 | 0 off, 1 payload, 2/3 whole cell |
| cfg_coset_en | input | 1 | XOR 0x55 into check value |
| cfg_correct_en | input | 1 | Allow single-bit header repair |
| cfg_drop_errored | input | 1 | Discard cells with unrepaired errors |
| cfg_drop_idle | input | 1 | Discard idle cells |
| cfg_drop_unassigned | input | 1 | Discard unassigned cells |
| cfg_drop_invalid | input | 1 | Discard invalid cells |
| cfg_drop_match | input | 1 | Discard matching cells |
| cfg_match_only | input | 1 | Forward matching cells only |
| cfg_hdr_value | input | 32 | Header compare value |
| cfg_hdr_mask | input | 32 | Header compare mask |
| cfg_hec_keep | input | 1 | Forward the check byte |
| cnt_latch | input | 1 | Latch and clear tallies |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of cell |
| out_eof | output | 1 | Last byte of cell |
| sync_state | output | 2 | 0 search, 1 provisional, 2 locked |
| corr_count | output | CNT_W | Latched repaired tally |
| uncorr_count | output | CNT_W | Latched unrepaired tally |

## Verification
A clean run of aligned cells with correct headers exercises acquisition. It shows that the sixth provisional match, and not the first, opens the output. Single-bit flips in a header bit and in a check-byte bit, sent back to back and then apart, separate repair from detection-only handling, and the tallies confirm which path each cell took. Headers chosen at the edges of the idle, unassigned, invalid and match classes show which drop bit governs each cell. Scrambled streams in both descrambler scopes, a run of seven corrupted headers, and a stream whose check value lacks the coset show that payload is recovered, that lock is lost on exactly the seventh error, and that the coset switch changes what counts as a valid header.

// File: rtl/atm_cell_delineator.sv
module atm_cell_delineator #(
  parameter int ALPHA = 7,
  parameter int DELTA = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic [1:0]       cfg_dscr_mode,
  input  logic             cfg_coset_en,
  input  logic             cfg_correct_en,
  input  logic             cfg_drop_errored,
  input  logic             cfg_drop_idle,
  input  logic             cfg_drop_unassigned,
  input  logic             cfg_drop_invalid,
  input  logic             cfg_drop_match,
  input  logic             cfg_match_only,
  input  logic [31:0]      cfg_hdr_value,
  input  logic [31:0]      cfg_hdr_mask,
  input  logic             cfg_hec_keep,
  input  logic             cnt_latch,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [1:0]       sync_state,
  output logic [CNT_W-1:0] corr_count,
  output logic [CNT_W-1:0] uncorr_count
);
  localparam int RUN_W = $clog2((ALPHA > DELTA) ? ALPHA : DELTA) + 1;
  localparam logic [RUN_W-1:0] RUN_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [1:0] ST_HUNT = 2'd0, ST_PRE = 2'd1, ST_SYNC = 2'd2;

  logic [1:0]       state;
  logic [5:0]       pos;
  logic [2:0]       fill;
  logic [4:0][7:0]  sr;
  logic [42:0]      dhist;
  logic [RUN_W-1:0] run;
  logic             corr_mode, accept;
  logic [CNT_W-1:0] cnt_corr, cnt_unc;
  logic [39:0]      flip;

  function automatic logic [7:0] crc8(input logic [31:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  wire        pay_pos  = (state != ST_HUNT) && (pos >= 6'd5);
  wire        ds_all   = cfg_dscr_mode[1];
  wire        ds_on    = ds_all || (cfg_dscr_mode[0] && pay_pos);
  wire        hist_upd = ds_all || pay_pos;
  wire [7:0]  din      = ds_on ? (in_data ^ dhist[42:35]) : in_data;
  wire [31:0] hdr_rx   = {sr[3], sr[2], sr[1], sr[0]};
  wire [7:0]  syn      = crc8(hdr_rx) ^ (cfg_coset_en ? 8'h55 : 8'h00) ^ din;
  wire        hec_ok   = (syn == 8'h00);
  wire        check    = in_valid && (fill == 3'd4) && (state == ST_HUNT || pos == 6'd4);

  always_comb begin
    flip = '0;
    for (int k = 0; k < 32; k++)
      if (crc8(32'd1 << k) == syn) flip[k+8] = 1'b1;
    for (int j = 0; j < 8; j++)
      if (syn == (8'd1 << j)) flip[j] = 1'b1;
  end

  wire        do_fix  = (state == ST_SYNC) && cfg_correct_en && corr_mode && !hec_ok && (|flip);
  wire        bad_unc = !hec_ok && !do_fix;
  wire        lose    = (state == ST_SYNC) && bad_unc && (run == RUN_W'(ALPHA - 1));
  wire [39:0] cw      = {hdr_rx, din} ^ (do_fix ? flip : 40'd0);
  wire [31:0] hdr     = cw[39:8];
  wire        vc_zero = (hdr[27:4] == 24'd0);
  wire        is_idle = (hdr == 32'h0000_0001);
  wire        is_unas = vc_zero && !hdr[0];
  wire        is_inv  = vc_zero && hdr[0] && !is_idle;
  wire        is_mat  = ((hdr ^ cfg_hdr_value) & cfg_hdr_mask) == 32'd0;
  wire        cls_drop = cfg_match_only ? !is_mat :
                         ((is_idle && cfg_drop_idle) || (is_unas && cfg_drop_unassigned) ||
                          (is_inv && cfg_drop_invalid) || (is_mat && cfg_drop_match));
  wire        drop    = cls_drop || (bad_unc && cfg_drop_errored);
  wire [5:0]  idx     = (pos >= 6'd5) ? pos - 6'd5 : pos + 6'd48;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT; pos <= '0; fill <= '0; sr <= '0; dhist <= '0;
      run <= '0; corr_mode <= 1'b0; accept <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
    end else if (in_valid) begin
      if (fill != 3'd4) fill <= fill + 3'd1;
      if (hist_upd) dhist <= {dhist[34:0], in_data};
      out_valid <= accept && !(idx == 6'd4 && !cfg_hec_keep);
      out_data  <= sr[4];
      out_sof   <= accept && (idx == 6'd0);
      out_eof   <= accept && (idx == 6'd52);
      pos <= (pos == 6'd52) ? 6'd0 : pos + 6'd1;
      if (check) begin
        sr     <= cw;
        accept <= (state == ST_SYNC) && !lose && !drop;
        case (state)
          ST_HUNT: if (hec_ok) begin state <= ST_PRE; run <= '0; pos <= 6'd5; end
          ST_PRE: begin
            if (!hec_ok) state <= ST_HUNT;
            else if (run == RUN_W'(DELTA - 1)) begin
              state <= ST_SYNC; run <= '0; corr_mode <= 1'b1;
            end else run <= run + RUN_ONE;
          end
          default: begin
            corr_mode <= hec_ok;
            if (!bad_unc) run <= '0;
            else if (lose) begin state <= ST_HUNT; run <= '0; end
            else run <= run + RUN_ONE;
          end
        endcase
      end else begin
        sr <= {sr[3:0], din};
      end
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
    end
  end

  wire inc_c = check && do_fix;
  wire inc_u = check && (state == ST_SYNC) && bad_unc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_corr <= '0; cnt_unc <= '0; corr_count <= '0; uncorr_count <= '0;
    end else if (cnt_latch) begin
      corr_count <= cnt_corr; uncorr_count <= cnt_unc;
      cnt_corr <= inc_c ? CNT_ONE : '0;
      cnt_unc  <= inc_u ? CNT_ONE : '0;
    end else begin
      if (inc_c && cnt_corr != '1) cnt_corr <= cnt_corr + CNT_ONE;
      if (inc_u && cnt_unc != '1)  cnt_unc  <= cnt_unc + CNT_ONE;
    end
  end

  assign sync_state = state;
endmodule

// File: rtl/atm_cell_delineator_chk.sv
module atm_cell_delineator_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic [1:0]       sync_state,
  input logic             cnt_latch,
  input logic [CNT_W-1:0] cnt_corr,
  input logic [CNT_W-1:0] cnt_unc
);
  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_state != 2'd3);
  // R1
  out_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R3
  fwd_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(sync_state) == 2'd2));
  // R2
  no_skip_presync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd2) |-> ($past(sync_state) != 2'd0));
  // R10
  marks_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);
  // R14
  latch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_latch |=> (cnt_corr <= CNT_W'(1) && cnt_unc <= CNT_W'(1)));
endmodule

bind atm_cell_delineator atm_cell_delineator_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_sof(out_sof), .out_eof(out_eof), .sync_state(sync_state),
  .cnt_latch(cnt_latch), .cnt_corr(cnt_corr), .cnt_unc(cnt_unc)
);

// File: tb/atm_cell_delineator_tb_top.sv
module atm_cell_delineator_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, cnt_latch = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_dscr_mode = 2'd0;
  logic cfg_coset_en = 1'b1, cfg_correct_en = 1'b0, cfg_drop_errored = 1'b1;
  logic cfg_drop_idle = 1'b0, cfg_drop_unassigned = 1'b0, cfg_drop_invalid = 1'b0;
  logic cfg_drop_match = 1'b0, cfg_match_only = 1'b0, cfg_hec_keep = 1'b1;
  logic [31:0] cfg_hdr_value = '0, cfg_hdr_mask = '0;
  logic out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [1:0] sync_state;
  logic [2:0] corr_count, uncorr_count;

  atm_cell_delineator #(.CNT_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_dscr_mode(cfg_dscr_mode), .cfg_coset_en(cfg_coset_en),
    .cfg_correct_en(cfg_correct_en), .cfg_drop_errored(cfg_drop_errored),
    .cfg_drop_idle(cfg_drop_idle), .cfg_drop_unassigned(cfg_drop_unassigned),
    .cfg_drop_invalid(cfg_drop_invalid), .cfg_drop_match(cfg_drop_match),
    .cfg_match_only(cfg_match_only), .cfg_hdr_value(cfg_hdr_value),
    .cfg_hdr_mask(cfg_hdr_mask), .cfg_hec_keep(cfg_hec_keep), .cnt_latch(cnt_latch),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .sync_state(sync_state), .corr_count(corr_count), .uncorr_count(uncorr_count)
  );

  int compared = 0, mismatched = 0, seed = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];
  logic [42:0] bh = '0;
  logic [9:0] e;
  string t;

  function automatic logic [7:0] hec_of(input logic [31:0] h, input logic cos);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 32; i++)
      r = (r[7] ^ h[31-i]) ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return cos ? (r ^ 8'h55) : r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [39:0] emask,
                           input bit fwd, input bit fixed, input string tag);
    logic [39:0] good, rx;
    logic [7:0] b, ln;
    bit pay;
    good = {hdr, hec_of(hdr, cfg_coset_en)};
    rx = good ^ emask;
    if (fwd) begin
      for (int i = 0; i < 5; i++)
        if (i != 4 || cfg_hec_keep) begin
          b = fixed ? good[39-8*i -: 8] : rx[39-8*i -: 8];
          exp_q.push_back({b, (i == 0), 1'b0}); tag_q.push_back(tag);
        end
      for (int i = 0; i < 48; i++) begin
        exp_q.push_back({8'(seed + i), 1'b0, (i == 47)}); tag_q.push_back(tag);
      end
    end
    for (int i = 0; i < 53; i++) begin
      pay = (i >= 5);
      b = pay ? 8'(seed + i - 5) : rx[39-8*i -: 8];
      ln = b;
      if (cfg_dscr_mode[1] || (cfg_dscr_mode[0] && pay)) ln = b ^ bh[42:35];
      if (cfg_dscr_mode[1] || pay) bh = {bh[34:0], ln};
      @(negedge clk); in_valid = 1'b1; in_data = ln;
    end
    @(negedge clk); in_valid = 1'b0;
    seed += 7;
  endtask

  task automatic latch_counts();
    @(negedge clk); cnt_latch = 1'b1;
    @(negedge clk); cnt_latch = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R3 unexpected byte: actual %02h expected none", out_data);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if ({out_data, out_sof, out_eof} !== e) begin
          mismatched++;
          $display("FAIL %s byte/sof/eof: actual %03h expected %03h", t,
                   {out_data, out_sof, out_eof}, e);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    compared++; mismatched++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state", sync_state, 0);
    check("R1 valid", out_valid, 0);
    check("R1 counts", {corr_count, uncorr_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_cell(32'h0123_4560, 40'd0, 0, 0, "R2");
    check("R2 presync after first match", sync_state, 1);
    for (int n = 0; n < 5; n++) begin
      send_cell(32'h0123_4560 + 32'(n << 4), 40'd0, 0, 0, "R3");
      check("R3 still presync", sync_state, 1);
    end
    send_cell(32'h0123_45A0, 40'd0, 0, 0, "R3");
    check("R3 sync after six", sync_state, 2);
    send_cell(32'h0A0B_0C00, 40'd0, 1, 0, "R3 first fwd");
    send_cell(32'h0A0B_0C10, 40'd0, 1, 0, "R3 fwd");
    send_cell(32'h0A0B_0C20, 40'd0, 1, 0, "R3 fwd");
    // R5 and R6
    cfg_correct_en = 1'b1;
    send_cell(32'h0A0B_0C30, {32'h0001_0000, 8'h00}, 1, 1, "R5 hdr repair");
    send_cell(32'h0A0B_0C40, {32'h0001_0000, 8'h00}, 0, 0, "R6 detect only");
    send_cell(32'h0A0B_0C50, 40'd0, 1, 0, "R6 good");
    send_cell(32'h0A0B_0C60, 40'h04, 1, 1, "R5 hec repair");
    send_cell(32'h0A0B_0C70, 40'd0, 1, 0, "R5 good");
    latch_counts();
    check("R5 repaired tally", corr_count, 2);
    check("R6 unrepaired tally", uncorr_count, 1);
    latch_counts();
    check("R14 cleared", {corr_count, uncorr_count}, 0);
    // R7
    cfg_correct_en = 1'b0; cfg_drop_errored = 1'b0;
    send_cell(32'h0A0B_0C80, {32'h0000_0100, 8'h00}, 1, 0, "R7 pass errored");
    send_cell(32'h0A0B_0C90, 40'd0, 1, 0, "R7 good");
    cfg_drop_errored = 1'b1;
    // R8
    cfg_drop_idle = 1'b1;
    send_cell(32'h0000_0001, 40'd0, 0, 0, "R8 idle dropped");
    cfg_drop_idle = 1'b0;
    send_cell(32'h0000_0001, 40'd0, 1, 0, "R8 idle kept");
    cfg_drop_unassigned = 1'b1;
    send_cell(32'h0000_000A, 40'd0, 0, 0, "R8 unassigned dropped");
    cfg_drop_invalid = 1'b1;
    send_cell(32'h0000_0003, 40'd0, 0, 0, "R8 invalid dropped");
    send_cell(32'h0000_0001, 40'd0, 1, 0, "R8 idle not invalid");
    cfg_drop_unassigned = 1'b0; cfg_drop_invalid = 1'b0;
    cfg_hdr_value = 32'h0ABC_DE00; cfg_hdr_mask = 32'hFFFF_FFF0; cfg_drop_match = 1'b1;
    send_cell(32'h0ABC_DE02, 40'd0, 0, 0, "R8 match dropped");
    send_cell(32'h0ABC_DF00, 40'd0, 1, 0, "R8 nonmatch kept");
    cfg_drop_match = 1'b0;
    // R9
    cfg_match_only = 1'b1; cfg_drop_idle = 1'b1;
    send_cell(32'h0ABC_DE05, 40'd0, 1, 0, "R9 match kept");
    send_cell(32'h0123_4560, 40'd0, 0, 0, "R9 nonmatch dropped");
    cfg_match_only = 1'b0; cfg_drop_idle = 1'b0;
    // R13
    cfg_coset_en = 1'b0;
    send_cell(32'h0D0E_0F00, 40'd0, 1, 0, "R13 no coset");
    check("R13 lock kept", sync_state, 2);
    cfg_coset_en = 1'b1;
    // R10
    cfg_hec_keep = 1'b0;
    send_cell(32'h0D0E_0F10, 40'd0, 1, 0, "R10 hec omitted");
    cfg_hec_keep = 1'b1;
    send_cell(32'h0D0E_0F20, 40'd0, 1, 0, "R10 hec kept");
    // R11
    cfg_dscr_mode = 2'd1;
    for (int n = 0; n < 3; n++) send_cell(32'h0D0E_0F30, 40'd0, 1, 0, "R11 payload descramble");
    // R12
    cfg_dscr_mode = 2'd2;
    for (int n = 0; n < 3; n++) send_cell(32'h0D0E_0F40, 40'd0, 1, 0, "R12 whole descramble");
    check("R12 lock kept", sync_state, 2);
    cfg_dscr_mode = 2'd0;
    send_cell(32'h0D0E_0F50, 40'd0, 1, 0, "R12 back to clear");
    // R4 and R14
    latch_counts();
    send_cell(32'h0D0E_0F60, 40'hFF, 0, 0, "R14 errored");
    send_cell(32'h0D0E_0F70, 40'd0, 1, 0, "R4 run reset");
    for (int n = 0; n < 6; n++) send_cell(32'h0D0E_0F80, 40'hFF, 0, 0, "R4 bad");
    check("R4 lock kept after six", sync_state, 2);
    send_cell(32'h0D0E_0F80, 40'hFF, 0, 0, "R4 bad");
    check("R4 search after seven", sync_state, 0);
    latch_counts();
    check("R14 saturated", uncorr_count, 7);
    check("R14 repaired zero", corr_count, 0);
    repeat (20) @(negedge clk);
    check("R3 all expected bytes seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule